// File: doc/BRIEF.md
# Indirect Register Access Bridge

The bridge lets a host reach a bank of byte-wide inner registers through a single 32-bit command word. The host writes one word that carries a target address, a data byte and a direction flag. The bridge latches that command and drives the inner register port for a fixed number of cycles. During that window it raises a busy flag. On the last cycle a write is committed or a read byte is captured. The host learns the result by reading the same word back: busy sits in one bit and the byte that was read sits in the top field.

Inner accesses have a fixed latency, set by a parameter, so the bridge needs no handshake from the register side. A command is taken only while the bridge is idle, and the host must poll busy before it trusts the read field.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the readback word is all zeros, busy (bit 23) is low and the inner select is low.
- R2: A host write with bit 16 set writes the byte in bits 15:8 into the inner register addressed by bits 7:0. The write commits on the last cycle of the access.
- R3: A host write with bit 16 clear starts an inner read of the address in bits 7:0. When busy falls, bits 31:24 hold the byte read.
- R4: Busy rises in the cycle after a command is accepted and stays high for exactly ACCESS_CYCLES cycles.
- R5: A host write that arrives while busy is high is ignored. The latched address, data and direction are unchanged, busy continues, and no extra inner access occurs.
- R6: Bits 31:24 keep their last value through write accesses, and while a read is in flight, until the next read completes.
- R7: The inner select is high exactly while busy. Inner address, direction and write data stay stable during an access. The commit strobe pulses exactly once per access, in its last cycle.
- R8: Readback bits 7:0, 15:8 and 16 echo the last accepted command. Bits 22:17 read as zero, and host bits 31:17 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr_en | input | 1 | Host writes a command word this cycle |
| host_wr_data | input | 32 | Command word: address 7:0, data 15:8, write flag 16 |
| host_word | output | 32 | Readback word: command echo, busy at 23, read byte at 31:24 |
| inner_sel | output | 1 | Inner access in progress |
| inner_commit | output | 1 | Last cycle of the inner access (write commits, read sampled) |
| inner_we | output | 1 | Inner access direction, 1 for write |
| inner_addr | output | 8 | Inner register address |
| inner_wdata | output | 8 | Inner write byte |
| inner_rdata | input | 8 | Inner read byte for inner_addr, valid on the commit cycle |

## Verification
The assertions assume that the inner register bank answers a read with a byte that belongs to the current inner address by the commit cycle. They make no assumption about when the host writes. The stimulus keeps to this by modelling the inner bank as an array read combinationally at inner_addr. Random commands arrive back to back, and some are thrown deliberately into the busy window, so the busy-time drop rule is exercised without any host-side constraint.

// File: rtl/ireg_bridge_pkg.sv
package ireg_bridge_pkg;
   // Outer command/readback word geometry; the host decodes these positions.
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned ADDR_LSB   = 0;
   localparam int unsigned WDATA_LSB  = 8;
   localparam int unsigned WE_BIT     = 16;
   localparam int unsigned BUSY_BIT   = 23;
   localparam int unsigned RDATA_LSB  = 24;
   localparam int unsigned FIELD_W    = 8;

   typedef struct packed {
      logic       we;
      logic [7:0] wdata;
      logic [7:0] addr;
   } ireg_cmd_t;
endpackage

// File: rtl/ireg_cmd_capture.sv
module ireg_cmd_capture
   import ireg_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [WORD_W-1:0] host_wr_data,
   input  logic              busy,
   output logic              start,
   output ireg_cmd_t         cmd
);
   localparam int unsigned HI_LSB = WE_BIT + 1;

   ireg_cmd_t cmd_d;
   logic      accept;
   logic [WORD_W-1:HI_LSB] unused_hi;

   assign unused_hi = host_wr_data[WORD_W-1:HI_LSB];

   always_comb begin
      cmd_d.addr  = host_wr_data[ADDR_LSB  +: ADDR_W];
      cmd_d.wdata = host_wr_data[WDATA_LSB +: DATA_W];
      cmd_d.we    = host_wr_data[WE_BIT];
   end

   assign accept = host_wr_en && !busy;
   assign start  = accept;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd <= '0;
      end else if (accept) begin
         cmd <= cmd_d;
      end
   end

   // R5
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && busy) |=> $stable(cmd));
endmodule

// File: rtl/ireg_access_seq.sv
module ireg_access_seq #(
   parameter int unsigned ACCESS_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic last
);
   if (ACCESS_CYCLES == 1) begin : g_single
      logic busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= start;
      end
      assign busy = busy_q;
      assign last = busy_q;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(ACCESS_CYCLES + 1);
      localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_CYCLES);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n)              cnt_q <= '0;
         else if (start)          cnt_q <= CNT_LOAD;
         else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
      end
      assign busy = (cnt_q != '0);
      assign last = (cnt_q == CNT_W'(1));
   end

   // R4
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R4
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !start) |=> !busy);
   // R7
   commit_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> busy);
endmodule

// File: rtl/ireg_rdata_hold.sv
module ireg_rdata_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              last,
   input  logic              we,
   input  logic [DATA_W-1:0] inner_rdata,
   output logic [DATA_W-1:0] rdata
);
   logic take;
   assign take = last && !we;

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata <= '0;
      else if (take) rdata <= inner_rdata;
   end

   // R6
   rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(last && !we) |=> $stable(rdata));
   // R3
   rdata_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && !we) |=> (rdata == $past(inner_rdata)));
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
   import ireg_bridge_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned ACCESS_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [31:0]       host_wr_data,
   output logic [31:0]       host_word,
   output logic              inner_sel,
   output logic              inner_commit,
   output logic              inner_we,
   output logic [ADDR_W-1:0] inner_addr,
   output logic [DATA_W-1:0] inner_wdata,
   input  logic [DATA_W-1:0] inner_rdata
);
   localparam int unsigned GAP_LSB = WE_BIT + 1;
   localparam int unsigned GAP_W   = BUSY_BIT - GAP_LSB;

   if (ADDR_W != FIELD_W) begin : g_bad_addr
      $error("ireg_bridge: ADDR_W must match the 8-bit address field");
   end
   if (DATA_W != FIELD_W) begin : g_bad_data
      $error("ireg_bridge: DATA_W must match the 8-bit data fields");
   end
   if (ACCESS_CYCLES < 1) begin : g_bad_lat
      $error("ireg_bridge: ACCESS_CYCLES must be at least 1");
   end

   ireg_cmd_t         cmd;
   logic              start;
   logic              busy;
   logic              last;
   logic [DATA_W-1:0] rdata;

   ireg_cmd_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_wr_en   (host_wr_en),
      .host_wr_data (host_wr_data),
      .busy         (busy),
      .start        (start),
      .cmd          (cmd)
   );

   ireg_access_seq #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .last  (last)
   );

   ireg_rdata_hold #(.DATA_W(DATA_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .last        (last),
      .we          (cmd.we),
      .inner_rdata (inner_rdata),
      .rdata       (rdata)
   );

   assign inner_sel    = busy;
   assign inner_commit = last;
   assign inner_we     = cmd.we;
   assign inner_addr   = cmd.addr;
   assign inner_wdata  = cmd.wdata;

   always_comb begin
      host_word                             = '0;
      host_word[ADDR_LSB  +: FIELD_W]       = cmd.addr;
      host_word[WDATA_LSB +: FIELD_W]       = cmd.wdata;
      host_word[WE_BIT]                     = cmd.we;
      host_word[GAP_LSB +: GAP_W]           = '0;
      host_word[BUSY_BIT]                   = busy;
      host_word[RDATA_LSB +: FIELD_W]       = rdata;
   end

   // R7
   inner_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inner_sel && $past(inner_sel) && !$past(inner_commit))
         |-> ($stable(inner_addr) && $stable(inner_we) && $stable(inner_wdata)));
   // R8
   gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_word[GAP_LSB +: GAP_W] == '0);
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> (host_word == '0));
endmodule

// File: tb/ireg_bridge_bench.sv
module ireg_bridge_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr_en = 1'b0;
   logic [31:0] host_wr_data = '0;
   logic [31:0] host_word;
   logic        inner_sel, inner_commit, inner_we;
   logic [7:0]  inner_addr, inner_wdata, inner_rdata;

   logic [7:0]  bank [256];
   logic [7:0]  ref_bank [256];
   logic [7:0]  last_rd;
   int          checks = 0, fails = 0, commits = 0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ireg_bridge #(.ACCESS_CYCLES(N)) u_ireg_bridge (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_word(host_word), .inner_sel(inner_sel), .inner_commit(inner_commit),
      .inner_we(inner_we), .inner_addr(inner_addr), .inner_wdata(inner_wdata),
      .inner_rdata(inner_rdata)
   );

   // inner register bank model
   assign inner_rdata = bank[inner_addr];
   always @(posedge clk) begin
      if (inner_commit && inner_we) bank[inner_addr] <= inner_wdata;
      if (inner_commit) commits <= commits + 1;
   end

   function automatic logic [16:0] echo(input logic [7:0] a, input logic [7:0] d, input logic w);
      return {w, d, a};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [7:0] a, input logic [7:0] d, input logic w, input bit inject);
      int c0;
      @(negedge clk);
      host_wr_en   = 1'b1;
      host_wr_data = {$urandom() & 32'hFFFE_0000} | {15'h0, w, d, a};
      c0 = commits;
      @(negedge clk);
      host_wr_en = 1'b0;
      chk(host_word[23] == 1'b1, "R4 busy rise", {31'h0, host_word[23]}, 32'h1);
      chk(host_word[16:0] == echo(a, d, w), "R8 echo", {15'h0, host_word[16:0]}, {15'h0, echo(a, d, w)});
      chk(host_word[22:17] == 6'h0, "R8 gap", {26'h0, host_word[22:17]}, 32'h0);
      chk(host_word[31:24] == last_rd, "R6 hold in flight", {24'h0, host_word[31:24]}, {24'h0, last_rd});
      if (inject && N > 1) begin
         host_wr_en   = 1'b1;
         host_wr_data = {15'h0, ~w, ~d, ~a};
      end
      for (int i = 1; i < N; i++) begin
         @(negedge clk);
         host_wr_en = 1'b0;
         chk(host_word[23] && inner_sel, "R4 busy hold", {30'h0, host_word[23], inner_sel}, 32'h3);
         chk(host_word[16:0] == echo(a, d, w), "R5 ignored cmd", {15'h0, host_word[16:0]}, {15'h0, echo(a, d, w)});
         chk(inner_addr == a && inner_we == w, "R7 inner stable", {23'h0, inner_we, inner_addr}, {23'h0, w, a});
      end
      @(negedge clk);
      chk(host_word[23] == 1'b0 && !inner_sel, "R4 busy fall", {31'h0, host_word[23]}, 32'h0);
      chk(commits - c0 == 1, "R7 one commit", commits - c0, 32'h1);
      if (w) ref_bank[a] = d;
      else   last_rd = ref_bank[a];
      chk(host_word[31:24] == last_rd, w ? "R6 hold after write" : "R3 read data",
          {24'h0, host_word[31:24]}, {24'h0, last_rd});
      if (w) begin
         chk(bank[a] == d, "R2 write committed", {24'h0, bank[a]}, {24'h0, d});
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      finish_run();
   end

   initial begin
      void'($urandom(32'h0000_5EED));
      for (int i = 0; i < 256; i++) begin
         bank[i] = 8'h00;
         ref_bank[i] = 8'h00;
      end
      last_rd = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(host_word == 32'h0 && !inner_sel, "R1 reset state", host_word, 32'h0);
      // directed corners
      do_cmd(8'h00, 8'hA5, 1'b1, 1'b0);      // R2 lowest address
      do_cmd(8'hFF, 8'h3C, 1'b1, 1'b1);      // R2 highest, R5 inject
      do_cmd(8'h00, 8'h00, 1'b0, 1'b0);      // R3 read back 0xA5
      do_cmd(8'h7E, 8'h11, 1'b0, 1'b1);      // R3 unwritten reads 0, R5
      do_cmd(8'hFF, 8'h00, 1'b0, 1'b0);      // R3
      do_cmd(8'h10, 8'hEE, 1'b1, 1'b1);      // R6 held over write
      do_cmd(8'h01, 8'h5A, 1'b1, 1'b0);      // R2 host upper bits random (R8)
      do_cmd(8'h01, 8'h00, 1'b0, 1'b0);      // R3
      // random traffic, addresses kept to a small window so reads hit writes
      for (int k = 0; k < 400; k++) begin
         logic [7:0] ra, rd;
         logic       rw;
         bit         ri;
         ra = 8'($urandom() & 32'h1F);
         if (($urandom() & 32'h7) == 0) ra = 8'hFF;
         rd = 8'($urandom());
         rw = 1'($urandom());
         ri = 1'($urandom());
         do_cmd(ra, rd, rw, ri);
      end
      finish_run();
   end
endmodule